// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block converts a single held request from an internal requester into one or two timed machine cycles on a shared address/data bus. A request carries an address, a direction (read or write), a space (memory or port), a size (byte or word) and write data. The block steps through the states T1, T2, T3, any number of wait states Tw and T4, one clock each. It drives the address latch strobe, the read and write strobes, the memory/port select, the transceiver direction and enable, and the upper-byte enable. For a read, it returns the captured data together with a one-clock completion pulse.

The low 16 bus lines carry the address in T1 and data afterwards. The upper lines carry the top address bits in T1 and a status nibble afterwards. A READY input is sampled at the end of T3 and at the end of each wait state, and it stretches the cycle until the external device is ready. Word accesses that cannot be done in one cycle are split into two byte cycles. This applies to odd addresses on the 16-bit bus, and to every word access when the block is built for an 8-bit data bus.

Top module: `bus_cycle_seq`

## Requirements
- R1: During and after reset, and whenever no request is in progress, the block is idle. In the idle state rd_n, wr_n and bhe_n are 1; ale, den, mio, dtr, req_done, ad_lo_oe and ad_hi_oe are 0.
- R2: From idle, a held req_valid enters T1 at the next clock edge. A cycle without waits occupies exactly four clocks, T1 to T4.
- R3: In T1, ale is 1 and ad_out carries the full address of the current byte cycle, with bit 0 as A0. Both ad_lo_oe and ad_hi_oe are 1. ale is 0 in every other state.
- R4: From T2 to T4, ad_out[19:16] carries the status {2'b00, req_write, req_mem}. In a read cycle ad_lo_oe is 0 in these states, so the low 16 lines are released.
- R5: rd_n is 0 only in T2, T3 and Tw of a read cycle, and it is 1 in T4. Read data is taken from ad_in at the clock edge that ends T3, or the last Tw. It appears on req_rdata in the cycle where req_done is 1.
- R6: In a write cycle, ad_lo_oe is 1 and wr_n is 0 from T2 to T4. During those states ad_out[15:0] holds the lane data. For a full word this is req_wdata. For a byte cycle it is the selected write byte, copied into both halves.
- R7: If ready is 0 at the edge that ends T3 or a Tw, one more Tw follows. Each low sample adds exactly one clock before T4.
- R8: While a cycle is in progress, mio equals req_mem and dtr equals req_write. den is 1 in T2, T3 and Tw, and also in T4 when the cycle is a write.
- R9: On the 16-bit bus, a word at an even address is one cycle with bhe_n=0 and A0=0. A byte at an odd address uses bhe_n=0 with A0=1 and the upper data lane. A byte at an even address uses bhe_n=1 with A0=0 and the lower lane. A byte read returns the byte in req_rdata[7:0], with req_rdata[15:8]=0.
- R10: On the 16-bit bus, a word at an odd address becomes two cycles. The first cycle uses the odd address, bhe_n=0 and the upper lane, and carries the low byte. The second uses address+1 (wrapping at 20 bits), A0=0, bhe_n=1 and the lower lane, and carries the high byte.
- R11: With the 8-bit bus option, bhe_n stays 1 at all times. Every byte uses data lines 7:0. A word becomes two cycles, at the address and then at address+1, low byte first.
- R12: req_done is a one-clock pulse in the T4 of the final byte cycle only. After it, the block returns to idle and accepts the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus state per period |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until req_done |
| req_addr | input | 20 | Byte address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = port space |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_wdata | input | 16 | Write data (byte accesses use bits 7:0) |
| req_done | output | 1 | One-clock completion pulse |
| req_rdata | output | 16 | Read result, valid with req_done |
| ad_out | output | 20 | Value driven on the multiplexed lines |
| ad_lo_oe | output | 1 | Drive enable for ad_out[15:0] |
| ad_hi_oe | output | 1 | Drive enable for ad_out[19:16] |
| ad_in | input | 16 | Value seen on the low bus lines |
| ale | output | 1 | Address latch strobe, high in T1 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| mio | output | 1 | 1 = memory cycle, 0 = port cycle |
| dtr | output | 1 | Transceiver direction, 1 = transmit |
| den | output | 1 | Transceiver enable, active high |
| bhe_n | output | 1 | Upper-byte enable, active low |
| ready | input | 1 | Device ready, sampled at end of T3/Tw |

## Verification
A READY rise and the capture of read data happen at the same clock edge. The edge that ends the final wait state both releases the cycle toward T4 and latches ad_in. The bench holds READY low for zero, one or two samples, and keeps ad_in at a junk value in every state except the one whose ending edge should capture. The returned word therefore matches the arithmetic memory pattern only if capture and READY release happen together. A second coincidence is the T4 of the first half of a split word, which flows straight into the next T1. The bench checks there that req_done stays low and that the strobes keep their positions.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_T3   = 3'd3,
      ST_TW   = 3'd4,
      ST_T4   = 3'd5
   } bus_st_e;
endpackage

// File: rtl/bcs_plan.sv
// Works out the byte-cycle plan for the held request: whether it is split,
// the address of the current sub-cycle and the lanes it uses.
module bcs_plan #(
   parameter int ADDR_W = 20,
   parameter bit NARROW = 1'b0
) (
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_word,
   input  logic              phase,
   output logic              split,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              both,
   output logic              hi_lane,
   output logic              bhe_n
);
   assign cur_addr = req_addr + {{(ADDR_W-1){1'b0}}, phase};

   generate
      if (NARROW) begin : g_narrow
         assign split   = req_word;
         assign both    = 1'b0;
         assign hi_lane = 1'b0;
         assign bhe_n   = 1'b1;
      end else begin : g_wide
         assign split   = req_word & req_addr[0];
         assign both    = req_word & ~req_addr[0];
         assign hi_lane = ~both & cur_addr[0];
         assign bhe_n   = ~(both | hi_lane);
      end
   endgenerate
endmodule

// File: rtl/bcs_fsm.sv
// T-state sequencer: T1, T2, T3, Tw*, T4, with a second pass for split words.
module bcs_fsm
   import bcs_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    req_valid,
   input  logic    ready,
   input  logic    split,
   output bus_st_e st,
   output logic    phase,
   output logic    done,
   output logic    capture
);
   bus_st_e nxt;
   logic    more;

   assign more = split & ~phase;

   always_comb begin
      nxt = st;
      case (st)
         ST_IDLE: nxt = req_valid ? ST_T1 : ST_IDLE;
         ST_T1:   nxt = ST_T2;
         ST_T2:   nxt = ST_T3;
         ST_T3:   nxt = ready ? ST_T4 : ST_TW;
         ST_TW:   nxt = ready ? ST_T4 : ST_TW;
         ST_T4:   nxt = more ? ST_T1 : ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         phase <= 1'b0;
      end else begin
         st <= nxt;
         if (st == ST_T4) phase <= more;
      end
   end

   assign done    = (st == ST_T4) & ~more;
   assign capture = ((st == ST_T3) | (st == ST_TW)) & ready;

   // R2: a held request leaves idle for T1 on the next edge
   a_r2_idle_to_t1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && req_valid) |=> (st == ST_T1));
   // R7: a low READY sample at the end of T3 inserts a wait state
   a_r7_wait_inserted: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_T3 || st == ST_TW) && !ready) |=> (st == ST_TW));
   // R12: completion is a single-clock pulse
   a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/bcs_lanes.sv
// Byte-lane steering for write data and assembly of read results.
module bcs_lanes #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              phase,
   input  logic              split,
   input  logic              both,
   input  logic              hi_lane,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] wr_lane,
   output logic [DATA_W-1:0] rdata
);
   localparam int BYTE_W = DATA_W / 2;

   logic [BYTE_W-1:0] wbyte;
   logic [BYTE_W-1:0] rbyte;

   assign wbyte   = (split & phase) ? req_wdata[DATA_W-1:BYTE_W] : req_wdata[BYTE_W-1:0];
   assign wr_lane = both ? req_wdata : {wbyte, wbyte};
   assign rbyte   = hi_lane ? ad_in[DATA_W-1:BYTE_W] : ad_in[BYTE_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (capture) begin
         if (both)
            rdata <= ad_in;
         else if (split & phase)
            rdata[DATA_W-1:BYTE_W] <= rbyte;
         else if (split)
            rdata[BYTE_W-1:0] <= rbyte;
         else
            rdata <= {{BYTE_W{1'b0}}, rbyte};
      end
   end

   // R9: a full-word cycle never also selects a single upper lane
   a_r9_lane_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(both && hi_lane));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
   import bcs_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16,
   parameter bit NARROW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_mem,
   input  logic              req_word,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_done,
   output logic [DATA_W-1:0] req_rdata,
   output logic [ADDR_W-1:0] ad_out,
   output logic              ad_lo_oe,
   output logic              ad_hi_oe,
   input  logic [DATA_W-1:0] ad_in,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic              mio,
   output logic              dtr,
   output logic              den,
   output logic              bhe_n,
   input  logic              ready
);
   localparam int HI_W = ADDR_W - DATA_W;

   generate
      if (DATA_W % 2 != 0) begin : g_bad_data
         $error("DATA_W must split into two equal byte lanes");
      end
      if (HI_W < 3) begin : g_bad_addr
         $error("ADDR_W must exceed DATA_W by at least 3 for the status lines");
      end
   endgenerate

   bus_st_e           st;
   logic              phase, done, capture;
   logic              split, both, hi_lane, plan_bhe_n;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] wr_lane, rdata;
   logic              busy, data_ph, tail;
   logic [HI_W-1:0]   status;

   bcs_plan #(.ADDR_W(ADDR_W), .NARROW(NARROW)) u_plan (
      .req_addr (req_addr),
      .req_word (req_word),
      .phase    (phase),
      .split    (split),
      .cur_addr (cur_addr),
      .both     (both),
      .hi_lane  (hi_lane),
      .bhe_n    (plan_bhe_n)
   );

   bcs_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .ready     (ready),
      .split     (split),
      .st        (st),
      .phase     (phase),
      .done      (done),
      .capture   (capture)
   );

   bcs_lanes #(.DATA_W(DATA_W)) u_lanes (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (capture),
      .phase     (phase),
      .split     (split),
      .both      (both),
      .hi_lane   (hi_lane),
      .req_wdata (req_wdata),
      .ad_in     (ad_in),
      .wr_lane   (wr_lane),
      .rdata     (rdata)
   );

   assign busy    = (st != ST_IDLE);
   assign data_ph = (st == ST_T2) | (st == ST_T3) | (st == ST_TW);
   assign tail    = data_ph | (st == ST_T4);
   assign status  = {{(HI_W-2){1'b0}}, req_write, req_mem};

   assign ale      = (st == ST_T1);
   assign rd_n     = ~(~req_write & data_ph);
   assign wr_n     = ~(req_write & tail);
   assign den      = data_ph | (req_write & (st == ST_T4));
   assign mio      = busy & req_mem;
   assign dtr      = busy & req_write;
   assign bhe_n    = busy ? plan_bhe_n : 1'b1;
   assign ad_lo_oe = ale | (req_write & tail);
   assign ad_hi_oe = busy;

   always_comb begin
      ad_out = '0;
      if (st == ST_T1) begin
         ad_out = cur_addr;
      end else if (busy) begin
         ad_out[ADDR_W-1:DATA_W] = status;
         if (req_write) ad_out[DATA_W-1:0] = wr_lane;
      end
   end

   assign req_done  = done;
   assign req_rdata = rdata;

   // R5: the read strobe only falls in the state right after the address strobe
   a_r5_rd_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n) |-> $past(ale));
   // R6: read and write strobes never overlap
   a_r6_no_strobe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));
   // R3: the address strobe lasts one state
   a_r3_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);
   // R4: while reading, the low lines are not driven
   a_r4_read_released: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_lo_oe);

   generate
      if (NARROW) begin : g_chk_narrow
         // R11: upper-byte enable unused on the 8-bit bus
         a_r11_no_bhe: assert property (@(posedge clk) disable iff (!rst_n)
            bhe_n);
      end
   endgenerate
endmodule

// File: tb/tb_bus_cycle_seq.sv
`timescale 1ns/1ps
module tb_bus_cycle_seq;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n;
   logic        vw, vn;
   logic [19:0] r_addr;
   logic        r_wr, r_mem, r_word;
   logic [15:0] r_wd;
   logic        ready;
   logic [15:0] ad_in;

   logic        w_done, w_lo, w_hi, w_ale, w_rd, w_wr, w_mio, w_dtr, w_den, w_bhe;
   logic [15:0] w_rdata;
   logic [19:0] w_ad;
   logic        n_done, n_lo, n_hi, n_ale, n_rd, n_wr, n_mio, n_dtr, n_den, n_bhe;
   logic [15:0] n_rdata;
   logic [19:0] n_ad;

   bus_cycle_seq dut (
      .clk(clk), .rst_n(rst_n), .req_valid(vw), .req_addr(r_addr),
      .req_write(r_wr), .req_mem(r_mem), .req_word(r_word), .req_wdata(r_wd),
      .req_done(w_done), .req_rdata(w_rdata), .ad_out(w_ad), .ad_lo_oe(w_lo),
      .ad_hi_oe(w_hi), .ad_in(ad_in), .ale(w_ale), .rd_n(w_rd), .wr_n(w_wr),
      .mio(w_mio), .dtr(w_dtr), .den(w_den), .bhe_n(w_bhe), .ready(ready));

   bus_cycle_seq #(.NARROW(1'b1)) dut_n (
      .clk(clk), .rst_n(rst_n), .req_valid(vn), .req_addr(r_addr),
      .req_write(r_wr), .req_mem(r_mem), .req_word(r_word), .req_wdata(r_wd),
      .req_done(n_done), .req_rdata(n_rdata), .ad_out(n_ad), .ad_lo_oe(n_lo),
      .ad_hi_oe(n_hi), .ad_in(ad_in), .ale(n_ale), .rd_n(n_rd), .wr_n(n_wr),
      .mio(n_mio), .dtr(n_dtr), .den(n_den), .bhe_n(n_bhe), .ready(ready));

   logic        sel;
   logic        o_done, o_lo, o_hi, o_ale, o_rd, o_wr, o_mio, o_dtr, o_den, o_bhe;
   logic [15:0] o_rdata;
   logic [19:0] o_ad;
   assign o_done  = sel ? n_done  : w_done;
   assign o_lo    = sel ? n_lo    : w_lo;
   assign o_hi    = sel ? n_hi    : w_hi;
   assign o_ale   = sel ? n_ale   : w_ale;
   assign o_rd    = sel ? n_rd    : w_rd;
   assign o_wr    = sel ? n_wr    : w_wr;
   assign o_mio   = sel ? n_mio   : w_mio;
   assign o_dtr   = sel ? n_dtr   : w_dtr;
   assign o_den   = sel ? n_den   : w_den;
   assign o_bhe   = sel ? n_bhe   : w_bhe;
   assign o_rdata = sel ? n_rdata : w_rdata;
   assign o_ad    = sel ? n_ad    : w_ad;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  finished = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s mode=%0d addr=%h act=%h exp=%h", tag, sel, r_addr, act, exp);
      end
   endtask

   function automatic logic [7:0] mb(input logic [19:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ {4'h0, a[19:16]} ^ 8'h5A;
   endfunction

   task automatic check_idle(input string tag);
      chk({tag, " R1 rd_n"}, o_rd, 1);
      chk({tag, " R1 wr_n"}, o_wr, 1);
      chk({tag, " R1 bhe_n"}, o_bhe, 1);
      chk({tag, " R1 ale"}, o_ale, 0);
      chk({tag, " R1 den"}, o_den, 0);
      chk({tag, " R1 mio"}, o_mio, 0);
      chk({tag, " R1 dtr"}, o_dtr, 0);
      chk({tag, " R1 lo_oe"}, o_lo, 0);
      chk({tag, " R1 hi_oe"}, o_hi, 0);
      chk({tag, " R12 done"}, o_done, 0);
   endtask

   // checks for T2, T3 and Tw
   task automatic check_mid(input logic w, input logic m, input logic [15:0] lane, input logic bhe);
      chk("R4 status", o_ad[19:16], {2'b00, w, m});
      chk("R4 hi_oe", o_hi, 1);
      chk("R4 lo_oe", o_lo, w);
      chk("R3 ale low", o_ale, 0);
      chk("R5 rd_n", o_rd, w);
      chk("R6 wr_n", o_wr, !w);
      chk("R8 den", o_den, 1);
      chk("R8 mio", o_mio, m);
      chk("R8 dtr", o_dtr, w);
      chk("R9 bhe_n", o_bhe, bhe);
      chk("R12 done", o_done, 0);
      if (w) chk("R6 lane data", o_ad[15:0], lane);
   endtask

   task automatic run(input logic narrow, input logic [19:0] a, input logic w, input logic m,
                      input logic wd, input logic [15:0] d, input int waits);
      int          n;
      logic [15:0] exp_r;
      sel    = narrow;
      r_addr = a; r_wr = w; r_mem = m; r_word = wd; r_wd = d;
      ready  = 1'b1;
      ad_in  = 16'hDEAD;
      n      = (wd && (narrow || a[0])) ? 2 : 1;
      exp_r  = 16'h0000;
      if (narrow) vn = 1'b1; else vw = 1'b1;
      @(negedge clk);
      for (int k = 0; k < n; k++) begin
         logic [19:0] ak;
         logic        both, hi, bhe;
         logic [7:0]  b;
         logic [15:0] lane, memv;
         ak   = a + 20'(k);
         both = !narrow && wd && !a[0];
         hi   = !narrow && !both && ak[0];
         bhe  = narrow ? 1'b1 : !(both || hi);
         b    = (n == 2 && k == 1) ? d[15:8] : d[7:0];
         lane = both ? d : {b, b};
         memv = narrow ? {8'hC3, mb(ak)} : {mb(ak | 20'h1), mb(ak & ~20'h1)};
         // T1 (R2 entry timing, R3 address phase)
         chk("R2 R3 ale in T1", o_ale, 1);
         chk("R3 address", o_ad, ak);
         chk("R3 lo_oe", o_lo, 1);
         chk("R3 hi_oe", o_hi, 1);
         chk(narrow ? "R11 bhe_n" : (n == 2 ? "R10 bhe_n" : "R9 bhe_n"), o_bhe, bhe);
         chk("R8 mio", o_mio, m);
         chk("R8 dtr", o_dtr, w);
         chk("R5 rd_n in T1", o_rd, 1);
         chk("R6 wr_n in T1", o_wr, 1);
         chk("R8 den in T1", o_den, 0);
         @(negedge clk);                      // T2
         check_mid(w, m, lane, bhe);
         ready = (waits == 0);
         @(negedge clk);                      // T3
         check_mid(w, m, lane, bhe);
         if (waits == 0) ad_in = memv;
         for (int j = 0; j < waits; j++) begin
            @(negedge clk);                   // Tw
            chk("R7 still in data phase", {o_rd, o_wr, o_den}, {w, !w, 1'b1});
            check_mid(w, m, lane, bhe);
            ad_in = 16'hDEAD;
            if (j == waits - 1) begin
               ready = 1'b1;
               ad_in = memv;
            end
         end
         @(negedge clk);                      // T4
         ad_in = 16'hBEEF;
         chk("R7 T4 reached after waits", o_den, w);
         chk("R5 rd_n released in T4", o_rd, 1);
         chk("R6 wr_n in T4", o_wr, !w);
         chk("R6 lo_oe in T4", o_lo, w);
         chk("R12 done only on last", o_done, (k == n - 1));
         if (w) chk("R6 lane data T4", o_ad[15:0], lane);
         if (both) exp_r = memv;
         else if (n == 2 && k == 0) exp_r[7:0] = hi ? memv[15:8] : memv[7:0];
         else if (n == 2) exp_r[15:8] = hi ? memv[15:8] : memv[7:0];
         else exp_r = {8'h00, hi ? memv[15:8] : memv[7:0]};
         if (k == n - 1) begin
            if (!w) chk(narrow ? "R11 read data" : (n == 2 ? "R10 read data" : "R5 R9 read data"),
                        o_rdata, exp_r);
            vw = 1'b0; vn = 1'b0;
         end
         @(negedge clk);
      end
      check_idle("after");
   endtask

   initial begin
      rst_n = 1'b0; vw = 1'b0; vn = 1'b0; ready = 1'b1; ad_in = '0;
      r_addr = '0; r_wr = 1'b0; r_mem = 1'b0; r_word = 1'b0; r_wd = '0; sel = 1'b0;
      repeat (3) @(negedge clk);
      sel = 1'b0; check_idle("reset wide");
      sel = 1'b1; check_idle("reset narrow");
      rst_n = 1'b1;
      @(negedge clk);
      sel = 1'b0; check_idle("post-reset");
      for (int md = 0; md < 2; md++)
         for (int i = 0; i < 16; i++)
            for (int wt = 0; wt < 3; wt++) begin
               logic [19:0] a;
               a = 20'h3C5A4 + 20'(i * 20'h1111 + wt * 20'h0203);
               a[0] = i[0];
               run(md[0], a, i[1], i[2], i[3], 16'(16'hA13C ^ (i * 16'h0F51) ^ (wt * 16'h3003)), wt);
            end
      // wrap at the top of the address space (R10, R11)
      run(1'b0, 20'hFFFFF, 1'b0, 1'b1, 1'b1, 16'h0000, 1);
      run(1'b0, 20'hFFFFF, 1'b1, 1'b1, 1'b1, 16'h6E91, 0);
      run(1'b1, 20'hFFFFF, 1'b0, 1'b0, 1'b1, 16'h0000, 2);
      // long wait run (R7)
      run(1'b0, 20'h12346, 1'b0, 1'b1, 1'b1, 16'h0000, 5);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired act=hung exp=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule